// File: doc/BRIEF.md
# Three-wire serial EEPROM slave front end

This block is the digital slave side of a 4096-bit serial EEPROM that speaks the three-wire Microwire protocol: a chip select, a serial clock and a serial data input, plus one serial data output that has its own output-enable so a pad can float it. The block runs on a fast system clock. It re-times the three serial inputs, finds the rising edges of the serial clock, and on each one decodes a start bit, a two-bit opcode, an address and, for a write, one data word. The storage is a register array inside the block.

The organization input picks the shape of the storage. High selects 256 words of 16 bits, and low selects 512 bytes. A pad pull-up outside the block keeps this input high when nothing drives it, so the 16-bit shape is the default. Reads may run on and stream word after word. Writes are guarded by a write-enable latch. A write is modelled as a self-timed operation of a fixed number of system clock cycles that begins when chip select is dropped. A host can poll for completion by raising chip select again and watching the data output.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset the data output is not enabled, the write-enable latch is clear, and every storage location reads as zero.
- R2: A read command is start bit 1, opcode 10, then the address MSB first. On the rising serial-clock edge that takes the last address bit, the output is enabled and drives one 0 bit. Each later rising edge presents the next data bit, MSB first.
- R3: While chip select stays high after a word has been sent, each further rising edge continues with the next address. The next word's MSB follows the previous word's LSB directly, with no extra 0 bit between the words.
- R4: A streaming read wraps from the last location (255 in 16-bit mode, 511 in byte mode) to location 0.
- R5: With the organization input high, addresses are 8 bits and words are 16 bits. With it low, addresses are 9 bits and words are 8 bits: byte address b lives in 16-bit word b>>1, in the upper half when b[0]=0 and in the lower half when b[0]=1.
- R6: Opcode 00 is a control command decided by the two most significant address bits. 11 sets the write-enable latch, and 00 clears it. The latch changes only through these commands or reset.
- R7: A write with the write-enable latch clear leaves the storage unchanged and starts no busy phase. Reads work whatever the latch holds.
- R8: A write is start bit 1, opcode 01, address, then one data word MSB first. After chip select falls, the storage updates once a fixed busy time has elapsed. While busy and with chip select high, the output is enabled and low. Once the write is done it is enabled and high.
- R9: Chip select low disables the output and returns the decoder to waiting for a start bit. A write cut short before its last data bit has no effect.
- R10: Rising edges that sample a data input of 0 before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; the decoder acts on its rising edges |
| di | input | 1 | Serial data input |
| org | input | 1 | Organization: 1 = 256 x 16, 0 = 512 x 8 |
| dout | output | 1 | Serial data output |
| dout_oe | output | 1 | Output enable for dout; 0 means high impedance |

## Verification
The bench streams reads across the top of the address space in both organizations. A decoder that wraps at the wrong width, or that puts another dummy 0 in front of each word, shifts every later bit and so fails the scoreboard. It writes a single byte in byte mode and reads it back as part of a 16-bit word, which catches a swapped half-word mapping. Writes issued with the latch clear, and writes cut short by chip select, must leave the data and the status output untouched. A design that ignores the latch or acts on partial words would show a busy indication or changed data. The busy and ready polling values are sampled on both sides of the self-timed interval, so a busy phase that never ends, or that is skipped, is reported.

// File: rtl/mw_pkg.sv
package mw_pkg;
    parameter int WORD_W = 16;
    parameter int LANES  = 2;
    parameter int WORDS  = 256;
    localparam int HALF_W = WORD_W / LANES;
    localparam int IDX_W  = $clog2(WORDS);
    localparam int ADDR_W = IDX_W + 1;
    localparam int CNT_W  = $clog2(WORD_W) + 1;

    localparam logic [1:0] OPC_CTRL  = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] CTL_EN    = 2'b11;
    localparam logic [1:0] CTL_DIS   = 2'b00;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_RD, ST_WDATA, ST_HOLD
    } mw_state_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  be;
    } wr_cmd_t;

    // Left-justify the selected item so its MSB is always bit WORD_W-1.
    function automatic logic [WORD_W-1:0] align_rd(input logic [WORD_W-1:0] w,
                                                   input logic org16,
                                                   input logic lo_half);
        if (org16)
            return w;
        else if (lo_half)
            return {w[HALF_W-1:0], {HALF_W{1'b0}}};
        else
            return {w[WORD_W-1:HALF_W], {HALF_W{1'b0}}};
    endfunction
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_q,
    output logic di_q,
    output logic sk_rise
);
    logic [2:0] pipe [STAGES];
    logic       sk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
            sk_prev <= 1'b0;
        end else begin
            pipe[0] <= {di, cs, sk};
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
            sk_prev <= pipe[STAGES-1][0];
        end
    end

    assign sk_rise = pipe[STAGES-1][0] & ~sk_prev;
    assign cs_q    = pipe[STAGES-1][1];
    assign di_q    = pipe[STAGES-1][2];
endmodule

// File: rtl/mw_array.sv
module mw_array
    import mw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  wr_cmd_t           wcmd,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rword
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [HALF_W-1:0] lane_mem [WORDS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < WORDS; i++) lane_mem[i] <= '0;
            end else if (we && wcmd.be[l]) begin
                lane_mem[wcmd.idx] <= wcmd.data[l*HALF_W +: HALF_W];
            end
        end

        assign rword[l*HALF_W +: HALF_W] = lane_mem[ridx];
    end
endmodule

// File: rtl/mw_busy.sv
module mw_busy #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (start)
            left <= CW'(CYCLES);
        else if (left != '0)
            left <= left - 1'b1;
    end

    assign busy = (left != '0);
    assign done = (left == CW'(1));

    // R8: the busy phase only ends through its completion strobe
    assert_busy_ends_done_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
    import mw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rise,
    input  logic              di,
    input  logic              org,
    input  logic              busy,
    input  logic [WORD_W-1:0] rd_word,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_go,
    output wr_cmd_t           wr_cmd,
    output logic              wel,
    output logic              dout,
    output logic              dout_oe
);
    mw_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        opc;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] wdat;
    logic              wr_armed;
    logic              stat_on;

    logic [CNT_W-1:0]  alen;
    logic [CNT_W-1:0]  wlen;
    logic [ADDR_W-1:0] addr_n;
    logic [ADDR_W-1:0] addr_inc;
    logic [WORD_W-1:0] aligned;
    logic [1:0]        top2;

    always_comb begin
        alen     = org ? CNT_W'(ADDR_W - 1) : CNT_W'(ADDR_W);
        wlen     = org ? CNT_W'(WORD_W) : CNT_W'(HALF_W);
        addr_n   = {addr[ADDR_W-2:0], di};
        addr_inc = org ? {1'b0, addr[IDX_W-1:0] + 1'b1} : addr + 1'b1;
        rd_idx   = org ? addr[IDX_W-1:0] : addr[ADDR_W-1:1];
        aligned  = align_rd(rd_word, org, addr[0]);
        top2     = org ? addr_n[ADDR_W-2 -: 2] : addr_n[ADDR_W-1 -: 2];
        wr_go    = !cs && (state == ST_HOLD) && wr_armed;
        wr_cmd.idx  = rd_idx;
        wr_cmd.data = org ? wdat : {LANES{wdat[HALF_W-1:0]}};
        wr_cmd.be   = org ? {LANES{1'b1}} : (addr[0] ? 2'b01 : 2'b10);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            opc      <= '0;
            addr     <= '0;
            sh       <= '0;
            wdat     <= '0;
            wr_armed <= 1'b0;
            stat_on  <= 1'b0;
            wel      <= 1'b0;
            dout     <= 1'b0;
            dout_oe  <= 1'b0;
        end else if (!cs) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            wr_armed <= 1'b0;
            dout     <= 1'b0;
            dout_oe  <= 1'b0;
            if (wr_go)
                stat_on <= 1'b1;
            else if (!busy)
                stat_on <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    dout_oe <= stat_on;
                    dout    <= !busy;
                    if (rise && di && !busy) begin
                        state   <= ST_OPC;
                        cnt     <= '0;
                        stat_on <= 1'b0;
                        dout_oe <= 1'b0;
                    end
                end
                ST_OPC: if (rise) begin
                    opc <= {opc[0], di};
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_ADDR;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ADDR: if (rise) begin
                    addr <= addr_n;
                    if (cnt == alen - 1'b1) begin
                        cnt <= '0;
                        case (opc)
                            OPC_READ: begin
                                state   <= ST_RD;
                                dout_oe <= 1'b1;
                                dout    <= 1'b0;
                            end
                            OPC_WRITE: state <= ST_WDATA;
                            OPC_CTRL: begin
                                if (top2 == CTL_EN)
                                    wel <= 1'b1;
                                else if (top2 == CTL_DIS)
                                    wel <= 1'b0;
                                state <= ST_HOLD;
                            end
                            default: state <= ST_HOLD;
                        endcase
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RD: if (rise) begin
                    if (cnt == '0) begin
                        dout <= aligned[WORD_W-1];
                        sh   <= {aligned[WORD_W-2:0], 1'b0};
                        cnt  <= wlen - 1'b1;
                        addr <= addr_inc;
                    end else begin
                        dout <= sh[WORD_W-1];
                        sh   <= {sh[WORD_W-2:0], 1'b0};
                        cnt  <= cnt - 1'b1;
                    end
                end
                ST_WDATA: if (rise) begin
                    wdat <= {wdat[WORD_W-2:0], di};
                    if (cnt == wlen - 1'b1) begin
                        state    <= ST_HOLD;
                        wr_armed <= wel;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: chip select low floats the output on the next cycle
    assert_float_on_deselect_R9: assert property (@(posedge clk) disable iff (rst)
        !cs |=> !dout_oe);
    // R6: the latch moves only on a decoded serial-clock edge
    assert_wel_only_on_edge_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rise) |-> $stable(wel));
    // R2: a read turns the output on with the leading zero
    assert_dummy_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD && $rose(dout_oe)) |-> !dout);
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
    import mw_pkg::*;
#(
    parameter int BUSY_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org,
    output logic dout,
    output logic dout_oe
);
    logic              cs_s, di_s, sk_rise;
    logic              busy, commit, wr_go, wel;
    logic [IDX_W-1:0]  rd_idx;
    logic [WORD_W-1:0] rd_word;
    wr_cmd_t           wr_cmd, pend;

    mw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di),
        .cs_q(cs_s), .di_q(di_s), .sk_rise(sk_rise)
    );

    mw_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cs(cs_s), .rise(sk_rise), .di(di_s), .org(org),
        .busy(busy), .rd_word(rd_word), .rd_idx(rd_idx), .wr_go(wr_go),
        .wr_cmd(wr_cmd), .wel(wel), .dout(dout), .dout_oe(dout_oe)
    );

    mw_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst(rst), .start(wr_go), .busy(busy), .done(commit)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pend <= '0;
        else if (wr_go)
            pend <= wr_cmd;
    end

    mw_array u_array (
        .clk(clk), .rst(rst), .we(commit), .wcmd(pend),
        .ridx(rd_idx), .rword(rd_word)
    );

    // R7: storage is only ever changed with the latch set
    assert_commit_needs_wel_R7: assert property (@(posedge clk) disable iff (rst)
        commit |-> wel);
    // R8: while busy an enabled output reads low
    assert_busy_shows_low_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && dout_oe) |-> !dout);
endmodule

// File: tb/tb_mw_eeprom_ctrl.sv
module tb_mw_eeprom_ctrl;
    localparam int SKH  = 8;
    localparam int BUSY = 40;

    logic clk = 1'b0, rst = 1'b1;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
    logic dout, dout_oe;

    int    n_chk = 0, n_fail = 0;
    bit    exp_q[$];
    string tag = "";
    bit    mon_on = 1'b0;
    bit    finished = 1'b0;
    logic [15:0] bmem [256];
    bit    bwel = 1'b0;

    mw_eeprom_ctrl #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .org(org),
        .dout(dout), .dout_oe(dout_oe)
    );

    always #10 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sbit(input bit b);
        di = b;
        tick(SKH);
        sk = 1'b1;
        tick(SKH);
        sk = 1'b0;
    endtask

    // monitor: pops one expected bit per serial-clock rise while enabled
    always begin
        @(posedge sk);
        if (mon_on && exp_q.size() > 0) begin
            bit e;
            tick(SKH - 1);
            e = exp_q.pop_front();
            chk(dout_oe === 1'b1 && dout === e, tag, {30'd0, dout_oe, dout},
                {30'd0, 1'b1, e});
        end
    end

    function automatic logic [15:0] bword(input bit o16, input int a);
        logic [15:0] w;
        if (o16) return bmem[a % 256];
        w = bmem[(a % 512) / 2];
        return (a % 2 == 1) ? {8'h00, w[7:0]} : {8'h00, w[15:8]};
    endfunction

    task automatic send_addr(input bit o16, input int a, input int skip_last);
        int aw = o16 ? 8 : 9;
        for (int i = 0; i < aw - skip_last; i++) sbit(bit'((a >> (aw - 1 - i)) & 1));
    endtask

    // driver: issue a read and push the whole expected bit stream
    task automatic rd(input bit o16, input int a, input int n, input int lead,
                      input string req);
        int aw = o16 ? 8 : 9;
        int ww = o16 ? 16 : 8;
        int sz = o16 ? 256 : 512;
        cs = 1'b1;
        tick(4);
        for (int i = 0; i < lead; i++) sbit(1'b0);
        sbit(1'b1); sbit(1'b1); sbit(1'b0);
        send_addr(o16, a, 1);
        exp_q.push_back(1'b0);
        for (int k = 0; k < n; k++) begin
            logic [15:0] w = bword(o16, (a + k) % sz);
            for (int j = ww - 1; j >= 0; j--) exp_q.push_back(w[j]);
        end
        tag = req;
        mon_on = 1'b1;
        sbit(bit'(a & 1));
        for (int k = 0; k < n * ww; k++) sbit(1'b0);
        mon_on = 1'b0;
        chk(exp_q.size() == 0, {req, " stream length"}, exp_q.size(), 0);
        exp_q.delete();
        cs = 1'b0;
        tick(6);
        chk(dout_oe === 1'b0, "R9 float after read", {31'd0, dout_oe}, 0);
        if (aw == 0) tick(1);
    endtask

    task automatic wr(input bit o16, input int a, input logic [15:0] d,
                      input string req);
        int ww = o16 ? 16 : 8;
        cs = 1'b1;
        tick(4);
        sbit(1'b1); sbit(1'b0); sbit(1'b1);
        send_addr(o16, a, 0);
        for (int j = ww - 1; j >= 0; j--) sbit(d[j]);
        cs = 1'b0;
        tick(4);
        cs = 1'b1;
        tick(6);
        if (bwel) begin
            chk(dout_oe === 1'b1 && dout === 1'b0, {req, " R8 busy low"},
                {30'd0, dout_oe, dout}, 32'h2);
            tick(BUSY + 10);
            chk(dout_oe === 1'b1 && dout === 1'b1, {req, " R8 ready high"},
                {30'd0, dout_oe, dout}, 32'h3);
            if (o16) begin
                bmem[a % 256] = d;
            end else if (a % 2 == 1) begin
                bmem[(a % 512) / 2][7:0] = d[7:0];
            end else begin
                bmem[(a % 512) / 2][15:8] = d[7:0];
            end
        end else begin
            chk(dout_oe === 1'b0, {req, " R7 no busy phase"}, {31'd0, dout_oe}, 0);
        end
        cs = 1'b0;
        tick(6);
    endtask

    task automatic ctl(input bit en);
        cs = 1'b1;
        tick(4);
        sbit(1'b1); sbit(1'b0); sbit(1'b0);
        sbit(en); sbit(en);
        for (int i = 0; i < 6; i++) sbit(1'b0);
        cs = 1'b0;
        tick(6);
        bwel = en;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 16'h0000;
        tick(5);
        rst = 1'b0;
        tick(3);
        // R1: output floats after reset, even with chip select high
        chk(dout_oe === 1'b0, "R1 reset float", {31'd0, dout_oe}, 0);
        cs = 1'b1;
        tick(6);
        chk(dout_oe === 1'b0, "R1 idle select float", {31'd0, dout_oe}, 0);
        cs = 1'b0;
        tick(4);
        rd(1, 5, 1, 0, "R1 zero contents");
        // R1/R7: latch clear after reset, write ignored
        wr(1, 5, 16'hDEAD, "R7 locked write");
        rd(1, 5, 1, 0, "R7 data kept");
        // R6: enable, then writes with status polling (R8)
        ctl(1'b1);
        wr(1, 5, 16'hA5C3, "R8 write 5");
        wr(1, 6, 16'h1234, "R8 write 6");
        wr(1, 255, 16'hBEEF, "R8 write 255");
        wr(1, 0, 16'h0F0F, "R8 write 0");
        rd(1, 5, 1, 0, "R2 single read");
        rd(1, 5, 3, 0, "R3 sequential read");
        rd(1, 255, 3, 0, "R4 wrap x16");
        // R5: byte organization
        org = 1'b0;
        tick(4);
        rd(0, 10, 3, 0, "R5 byte read");
        wr(0, 11, 16'h005A, "R5 byte write");
        rd(0, 511, 2, 0, "R4 wrap x8");
        org = 1'b1;
        tick(4);
        rd(1, 5, 1, 0, "R5 byte in word");
        // R6/R7: disable, write ignored, reads still work
        ctl(1'b0);
        wr(1, 6, 16'hFFFF, "R6 disabled write");
        rd(1, 6, 1, 0, "R7 read while locked");
        // R9: partial write aborted
        ctl(1'b1);
        cs = 1'b1;
        tick(4);
        sbit(1'b1); sbit(1'b0); sbit(1'b1);
        send_addr(1, 6, 0);
        for (int i = 0; i < 5; i++) sbit(1'b1);
        cs = 1'b0;
        tick(4);
        cs = 1'b1;
        tick(6);
        chk(dout_oe === 1'b0, "R9 aborted write no busy", {31'd0, dout_oe}, 0);
        cs = 1'b0;
        tick(6);
        rd(1, 6, 1, 0, "R9 aborted write data");
        // R9: read aborted mid-word
        cs = 1'b1;
        tick(4);
        sbit(1'b1); sbit(1'b1); sbit(1'b0);
        send_addr(1, 5, 0);
        for (int i = 0; i < 4; i++) sbit(1'b0);
        chk(dout_oe === 1'b1, "R9 read running", {31'd0, dout_oe}, 1);
        cs = 1'b0;
        tick(4);
        chk(dout_oe === 1'b0, "R9 abort float", {31'd0, dout_oe}, 0);
        tick(4);
        rd(1, 0, 2, 0, "R9 read after abort");
        // R10: leading zeros before start bit
        rd(1, 255, 1, 3, "R10 leading zeros");
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule